// File: doc/BRIEF.md
# Gain and Offset Step Controller

This block holds the digitizer's gain and offset settings as two up/down counters that a host nudges one count at a time. The host first writes a control register: two hold bits choose which counters may move, and a direction bit chooses up or down. Each write pulse on a separate step port then moves every counter that is not held by one count. The step port carries no meaningful data. Each counter value drives a DAC.

The control register also stores a zoom flag, a board-select flag and a three-bit page number. The block exposes these as outputs for other logic to use. The register reads back exactly what was last written. On reset both counters sit at midscale and the control register is zero.

Top module: `gain_offset_stepper`

## Requirements
- R1: Synchronous active-high reset clears the control register to 0x00 and loads both counters with 128.
- R2: A control write stores the 8-bit data, and the control read port shows that value from the next cycle on.
- R3: The stored control byte drives the zoom output from bit 0, the board-select output from bit 4 and the page output from bits 7:5.
- R4: On a step write the gain counter moves by one if control bit 1 is 0. It keeps its value if bit 1 is 1.
- R5: On a step write the offset counter moves by one if control bit 2 is 0. It keeps its value if bit 2 is 1.
- R6: Control bit 3 sets the direction of every step. A value of 1 increments the counter and a value of 0 decrements it.
- R7: A counter at 255 stays at 255 on an increment step. A counter at 0 stays at 0 on a decrement step.
- R8: Every clock cycle with the step strobe high produces exactly one step, whatever the step data. With the step strobe low, neither counter changes.
- R9: When a control write and a step write fall in the same cycle, the step uses the control value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control register write data |
| ctrl_rdata | output | 8 | Control register read-back value |
| step_we | input | 1 | Step register write strobe |
| step_wdata | input | 8 | Step register write data, ignored |
| gain_o | output | 8 | Gain counter value |
| offset_o | output | 8 | Offset counter value |
| zoom_o | output | 1 | Zoom flag |
| board_sel_o | output | 1 | Board select flag |
| page_o | output | 3 | Page number |

## Verification
The assertions assume that each high cycle of a strobe is one separate write, and that the strobes only matter outside reset. The bench drives both strobes as single-cycle pulses and also as back-to-back runs, so each high cycle is treated as its own write. The stimulus holds a direction long enough to reach both saturation limits. It also places a control write and a step write in the same cycle to show that the step uses the older control value.

// File: rtl/gos_pkg.sv
package gos_pkg;
  localparam int PAGE_W = 3;

  typedef struct packed {
    logic [PAGE_W-1:0] page;
    logic              board;
    logic              dir_up;
    logic              hold_off;
    logic              hold_gain;
    logic              zoom;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/gos_ctrl_reg.sv
module gos_ctrl_reg
  import gos_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output ctrl_t             ctrl_o
);
  always_ff @(posedge clk) begin
    if (rst) ctrl_o <= '0;
    else if (we_i) ctrl_o <= ctrl_t'(wdata_i);
  end

  // R2: a write is visible on the next cycle
  p_readback_r2: assert property (@(posedge clk) disable iff (rst)
    we_i |=> (ctrl_o == $past(wdata_i)));

  p_keep_r2: assert property (@(posedge clk) disable iff (rst)
    !we_i |=> $stable(ctrl_o));
endmodule

// File: rtl/gos_step_counter.sv
module gos_step_counter #(
  parameter int WIDTH   = 8,
  parameter int RST_VAL = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_i,
  input  logic             hold_i,
  input  logic             up_i,
  output logic [WIDTH-1:0] count_o
);
  localparam logic [WIDTH-1:0] MAXV = '1;
  localparam logic [WIDTH-1:0] MINV = '0;
  localparam logic [WIDTH-1:0] RSTV = WIDTH'(RST_VAL);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_o <= RSTV;
    end else if (step_i && !hold_i) begin
      if (up_i && count_o != MAXV) count_o <= count_o + 1'b1;
      else if (!up_i && count_o != MINV) count_o <= count_o - 1'b1;
    end
  end

  p_inc_r6: assert property (@(posedge clk) disable iff (rst)
    (step_i && !hold_i && up_i && count_o != MAXV) |=> (count_o == $past(count_o) + 1'b1));

  p_dec_r6: assert property (@(posedge clk) disable iff (rst)
    (step_i && !hold_i && !up_i && count_o != MINV) |=> (count_o == $past(count_o) - 1'b1));

  // R4 / R5: a held counter does not move
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (hold_i || !step_i) |=> $stable(count_o));

  p_sat_hi_r7: assert property (@(posedge clk) disable iff (rst)
    (count_o == MAXV && up_i) |=> (count_o == MAXV));

  p_sat_lo_r7: assert property (@(posedge clk) disable iff (rst)
    (count_o == MINV && !up_i) |=> (count_o == MINV));
endmodule

// File: rtl/gain_offset_stepper.sv
module gain_offset_stepper
  import gos_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int MID_VAL = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  output logic [CTRL_W-1:0] ctrl_rdata,
  input  logic              step_we,
  input  logic [7:0]        step_wdata,
  output logic [CNT_W-1:0]  gain_o,
  output logic [CNT_W-1:0]  offset_o,
  output logic              zoom_o,
  output logic              board_sel_o,
  output logic [PAGE_W-1:0] page_o
);
  localparam int N_CNT = 2;

  ctrl_t            ctrl;
  logic [N_CNT-1:0] hold;
  logic [CNT_W-1:0] cnt [N_CNT];
  logic [7:0]       unused_step_data;

  assign unused_step_data = step_wdata;

  gos_ctrl_reg i_ctrl (
    .clk     (clk),
    .rst     (rst),
    .we_i    (ctrl_we),
    .wdata_i (ctrl_wdata),
    .ctrl_o  (ctrl)
  );

  assign hold = {ctrl.hold_off, ctrl.hold_gain};

  for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
    gos_step_counter #(.WIDTH(CNT_W), .RST_VAL(MID_VAL)) i_cnt (
      .clk     (clk),
      .rst     (rst),
      .step_i  (step_we),
      .hold_i  (hold[i]),
      .up_i    (ctrl.dir_up),
      .count_o (cnt[i])
    );
  end

  assign gain_o      = cnt[0];
  assign offset_o    = cnt[1];
  assign ctrl_rdata  = ctrl;
  assign zoom_o      = ctrl.zoom;
  assign board_sel_o = ctrl.board;
  assign page_o      = ctrl.page;

  // R9: a step uses the control value held before a same-cycle write
  p_old_dir_r9: assert property (@(posedge clk) disable iff (rst)
    (step_we && ctrl_we && !ctrl.hold_gain && ctrl.dir_up && gain_o != '1)
      |=> (gain_o > $past(gain_o)));
endmodule

// File: tb/test_gain_offset_stepper.sv
module test_gain_offset_stepper;
  logic clk = 1'b0;
  logic rst;
  logic ctrl_we, step_we;
  logic [7:0] ctrl_wdata, step_wdata;
  logic [7:0] ctrl_rdata, gain_o, offset_o;
  logic zoom_o, board_sel_o;
  logic [2:0] page_o;

  int errors = 0;
  int checks = 0;
  int m_ctrl, m_gain, m_off;
  bit done = 0;

  always #2 clk = ~clk;

  gain_offset_stepper i_gain_offset_stepper (
    .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .ctrl_rdata(ctrl_rdata), .step_we(step_we), .step_wdata(step_wdata),
    .gain_o(gain_o), .offset_o(offset_o), .zoom_o(zoom_o),
    .board_sel_o(board_sel_o), .page_o(page_o)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    check({tag, " R2 ctrl"}, ctrl_rdata, m_ctrl);
    check({tag, " R4 gain"}, gain_o, m_gain);
    check({tag, " R5 offset"}, offset_o, m_off);
    check({tag, " R3 zoom"}, zoom_o, m_ctrl & 1);
    check({tag, " R3 board"}, board_sel_o, (m_ctrl >> 4) & 1);
    check({tag, " R3 page"}, page_o, (m_ctrl >> 5) & 7);
  endtask

  function automatic int step_one(int v, bit up);
    if (up) return (v < 255) ? v + 1 : 255;
    return (v > 0) ? v - 1 : 0;
  endfunction

  // one clock: drive at negedge, model at posedge, compare next negedge
  task automatic cycle(string tag, bit cw, int cd, bit sw, int sd);
    ctrl_we = cw; ctrl_wdata = 8'(cd); step_we = sw; step_wdata = 8'(sd);
    @(posedge clk);
    if (sw) begin
      if (((m_ctrl >> 1) & 1) == 0) m_gain = step_one(m_gain, m_ctrl[3]);
      if (((m_ctrl >> 2) & 1) == 0) m_off  = step_one(m_off, m_ctrl[3]);
    end
    if (cw) m_ctrl = cd;
    @(negedge clk);
    ctrl_we = 0; step_we = 0;
    compare_all(tag);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1; ctrl_we = 0; step_we = 0; ctrl_wdata = 0; step_wdata = 0;
    m_ctrl = 0; m_gain = 128; m_off = 128;
    repeat (3) @(negedge clk);
    rst = 0;
    compare_all("R1 reset");
    // R2/R3 field mapping
    cycle("R3 fields", 1, 8'hF1, 0, 0);
    cycle("R3 fields", 1, 8'h50, 0, 0);
    cycle("R8 idle", 0, 0, 0, 0);
    // R6 up, both enabled; saturate R7; step data ignored R8
    cycle("R6 setup", 1, 8'h08, 0, 0);
    for (int i = 0; i < 140; i++) cycle("R7 up", 0, 0, 1, i * 37);
    // R6 down to 0 and saturate
    cycle("R6 setup", 1, 8'h00, 0, 0);
    for (int i = 0; i < 270; i++) cycle("R7 down", 0, 0, 1, 255 - i);
    // R4 gain held, offset moves
    cycle("R4 setup", 1, 8'h0A, 0, 0);
    for (int i = 0; i < 5; i++) cycle("R4 hold", 0, 0, 1, 8'hFF);
    // R5 offset held, gain moves
    cycle("R5 setup", 1, 8'h0C, 0, 0);
    for (int i = 0; i < 7; i++) cycle("R5 hold", 0, 0, 1, 8'hAA);
    cycle("R5 both held", 1, 8'h0E, 0, 0);
    cycle("R5 both held", 0, 0, 1, 0);
    // R9 simultaneous writes
    cycle("R9 setup", 1, 8'h08, 0, 0);
    cycle("R9 same cycle", 1, 8'h00, 1, 0);
    cycle("R9 after", 1, 8'h06, 1, 0);
    cycle("R9 held", 0, 0, 1, 0);
    // R8 pulses separated by idle
    cycle("R8 setup", 1, 8'h08, 0, 0);
    for (int i = 0; i < 6; i++) begin
      cycle("R8 pulse", 0, 0, 1, i);
      cycle("R8 gap", 0, 0, 0, 8'h55);
    end
    // R1 reset again mid-run
    rst = 1; @(negedge clk); rst = 0;
    m_ctrl = 0; m_gain = 128; m_off = 128;
    compare_all("R1 re-reset");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule